// File: doc/BRIEF.md
# Multi-Port Atomic Memory Operation Unit

This block sits in front of a small single-ported word memory and arbitrates between several requester ports. It serves plain loads and stores, three indivisible read-modify-write operations (test-and-set, fetch-and-add and exchange), and a linked-load / conditional-store pair.

Each requester owns one reservation, made of a valid flag and a word address. A linked load creates the reservation. A conditional store succeeds only while that flag is still set. Writes from other requesters to the reserved word clear the reservation, and so does a per-requester context-switch pulse.

Requests use valid/ready handshakes, one per port. `req_ready[i]` is asserted only in a cycle where port i is granted, and it may depend on `req_valid[i]` in the same cycle. A requester must hold its valid and payload until the handshake completes.

Each accepted request produces exactly one response on the shared response channel, one cycle after acceptance. That response stays unchanged while `rsp_valid` is high and `rsp_ready` is low. No new request is accepted in that state.

Since the memory read and the memory write of an operation happen in the same grant cycle, nothing can reach memory between them.

Top module: `amo_unit`

## Requirements
- R1: After reset `rsp_valid` is 0 and every memory word reads as 0.
- R2: Opcode field `req_op[3*i+:3]` of port i uses these encodings: 0 load, 1 store, 2 test-and-set, 3 fetch-and-add, 4 exchange, 5 linked load, 6 conditional store, 7 acts as a load. A load returns the addressed word. A store writes the operand. Every response carries the word as it was before the operation, `rsp_ok` = 1 except for a failed conditional store, and `rsp_id` = the port index.
- R3: Test-and-set returns the old word and leaves the value 1 in that word.
- R4: Fetch-and-add returns the old word and writes old + operand, modulo 2^DW.
- R5: Exchange returns the old word and writes the operand.
- R6: A linked load returns the word and reserves its address for that requester. A conditional store from a requester whose reservation flag is set writes the operand, responds with `rsp_ok` = 1, and clears that requester's own reservation.
- R7: A conditional store from a requester with no reservation writes nothing and responds with `rsp_ok` = 0.
- R8: A write by any other requester to the reserved address clears a reservation. Writes include store, test-and-set, fetch-and-add, exchange and a successful conditional store. The requester's own plain writes and writes to other addresses leave the reservation intact.
- R9: A high `ctx_switch[i]` clears requester i's reservation at the next edge, taking precedence over a simultaneous linked load. Other requesters' reservations are unaffected.
- R10: At most one request is granted per cycle, in round-robin order among valid ports. Each grant yields a response on the next cycle. Concurrent test-and-set requests to one word see exactly one old value of 0.
- R11: While `rsp_valid` is 1 and `rsp_ready` is 0, no `req_ready` is raised and the response is held stable.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | NREQ | Request valid, one bit per port |
| req_ready | output | NREQ | Request accepted, one bit per port |
| req_op | input | 3*NREQ | Opcode per port |
| req_addr | input | AW*NREQ | Word address per port |
| req_wdata | input | DW*NREQ | Operand per port |
| ctx_switch | input | NREQ | Clears that port's reservation |
| rsp_valid | output | 1 | Response valid |
| rsp_ready | input | 1 | Response taken |
| rsp_id | output | IDW | Port that issued the request |
| rsp_rdata | output | DW | Word value before the operation |
| rsp_ok | output | 1 | 0 only for a failed conditional store |

## Verification
Each opcode is driven one request at a time through a vector table. Loads placed after each write expose both the returned old value and the stored new value, so a wrong write value is told apart from a wrong read value. Reservation sequences cover four cases: a successful conditional store followed by a retry, a foreign plain store, a foreign test-and-set, and an own store to the same word. These separate "reservation cleared" from "reservation kept", and writes to other addresses check that the address comparison is real. Three ports issuing test-and-set together, a context-switch pulse on the owner and on a foreign port, and a stalled response channel probe arbitration, atomicity and back-pressure.

// File: rtl/amo_pkg.sv
package amo_pkg;
  typedef enum logic [2:0] {
    AMO_LOAD  = 3'd0,
    AMO_STORE = 3'd1,
    AMO_TAS   = 3'd2,
    AMO_FADD  = 3'd3,
    AMO_SWAP  = 3'd4,
    AMO_LL    = 3'd5,
    AMO_SC    = 3'd6,
    AMO_RSVD  = 3'd7
  } amo_op_e;
endpackage

// File: rtl/amo_rr_arb.sv
module amo_rr_arb #(
  parameter int N   = 3,
  parameter int IDW = 2
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [N-1:0]   req,
  input  logic           en,
  output logic [N-1:0]   gnt,
  output logic [IDW-1:0] gnt_id,
  output logic           gnt_any
);
  logic [IDW-1:0] last_q;

  always_comb begin
    int idx;
    gnt     = '0;
    gnt_id  = '0;
    gnt_any = 1'b0;
    idx     = 0;
    if (en) begin
      for (int k = 1; k <= N; k++) begin
        idx = (int'(last_q) + k) % N;
        if (!gnt_any && req[idx]) begin
          gnt_any     = 1'b1;
          gnt[idx]    = 1'b1;
          gnt_id      = IDW'(idx);
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)       last_q <= IDW'(N - 1);
    else if (gnt_any) last_q <= gnt_id;
  end
endmodule

// File: rtl/amo_alu.sv
module amo_alu
  import amo_pkg::*;
#(
  parameter int DW = 16
) (
  input  amo_op_e       op,
  input  logic [DW-1:0] old_val,
  input  logic [DW-1:0] operand,
  input  logic          sc_pass,
  output logic [DW-1:0] new_val,
  output logic          we,
  output logic          ok
);
  always_comb begin
    new_val = operand;
    we      = 1'b0;
    ok      = 1'b1;
    unique case (op)
      AMO_STORE: we = 1'b1;
      AMO_TAS: begin
        we      = 1'b1;
        new_val = DW'(1);
      end
      AMO_FADD: begin
        we      = 1'b1;
        new_val = old_val + operand;
      end
      AMO_SWAP: we = 1'b1;
      AMO_SC: begin
        we = sc_pass;
        ok = sc_pass;
      end
      default: we = 1'b0;
    endcase
  end
endmodule

// File: rtl/amo_reservations.sv
module amo_reservations
  import amo_pkg::*;
#(
  parameter int N   = 3,
  parameter int AW  = 4,
  parameter int IDW = 2
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           fire,
  input  logic [IDW-1:0] gnt_id,
  input  amo_op_e        op,
  input  logic [AW-1:0]  addr,
  input  logic           mem_we,
  input  logic [N-1:0]   ctx_switch,
  output logic [N-1:0]   flag,
  output logic           sc_pass
);
  for (genvar r = 0; r < N; r++) begin : g_res
    logic          flag_q;
    logic [AW-1:0] addr_q;
    logic          mine;

    assign mine    = fire && (gnt_id == IDW'(r));
    assign flag[r] = flag_q;

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        flag_q <= 1'b0;
        addr_q <= '0;
      end else begin
        if (mine && op == AMO_LL) begin
          flag_q <= 1'b1;
          addr_q <= addr;
        end else if (mine && op == AMO_SC) begin
          flag_q <= 1'b0;
        end else if (fire && !mine && mem_we && addr_q == addr) begin
          flag_q <= 1'b0;
        end
        if (ctx_switch[r]) flag_q <= 1'b0;
      end
    end
  end

  always_comb begin
    sc_pass = 1'b0;
    for (int r = 0; r < N; r++)
      if (gnt_id == IDW'(r)) sc_pass = flag[r];
  end
endmodule

// File: rtl/amo_unit.sv
module amo_unit
  import amo_pkg::*;
#(
  parameter int NREQ = 3,
  parameter int AW   = 4,
  parameter int DW   = 16,
  localparam int IDW   = (NREQ > 1) ? $clog2(NREQ) : 1,
  localparam int DEPTH = 1 << AW
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NREQ-1:0]   req_valid,
  output logic [NREQ-1:0]   req_ready,
  input  logic [3*NREQ-1:0] req_op,
  input  logic [AW*NREQ-1:0] req_addr,
  input  logic [DW*NREQ-1:0] req_wdata,
  input  logic [NREQ-1:0]   ctx_switch,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [IDW-1:0]    rsp_id,
  output logic [DW-1:0]     rsp_rdata,
  output logic              rsp_ok
);
  logic [DW-1:0]   mem_q [DEPTH];
  logic [NREQ-1:0] gnt;
  logic [IDW-1:0]  gnt_id;
  logic            fire;
  logic            can_accept;
  amo_op_e         sel_op;
  logic [AW-1:0]   sel_addr;
  logic [DW-1:0]   sel_wdata;
  logic [DW-1:0]   old_val;
  logic [DW-1:0]   new_val;
  logic            mem_we;
  logic            op_ok;
  logic            sc_pass;
  logic [NREQ-1:0] res_flag;

  assign can_accept = !rsp_valid || rsp_ready;

  amo_rr_arb #(.N(NREQ), .IDW(IDW)) u_arb (
    .clk(clk), .rst_n(rst_n), .req(req_valid), .en(can_accept),
    .gnt(gnt), .gnt_id(gnt_id), .gnt_any(fire)
  );

  assign req_ready = gnt;

  always_comb begin
    sel_op    = AMO_LOAD;
    sel_addr  = '0;
    sel_wdata = '0;
    for (int i = 0; i < NREQ; i++) begin
      if (gnt[i]) begin
        sel_op    = amo_op_e'(req_op[i*3 +: 3]);
        sel_addr  = req_addr[i*AW +: AW];
        sel_wdata = req_wdata[i*DW +: DW];
      end
    end
  end

  assign old_val = mem_q[sel_addr];

  amo_reservations #(.N(NREQ), .AW(AW), .IDW(IDW)) u_res (
    .clk(clk), .rst_n(rst_n), .fire(fire), .gnt_id(gnt_id), .op(sel_op),
    .addr(sel_addr), .mem_we(mem_we), .ctx_switch(ctx_switch),
    .flag(res_flag), .sc_pass(sc_pass)
  );

  amo_alu #(.DW(DW)) u_alu (
    .op(sel_op), .old_val(old_val), .operand(sel_wdata), .sc_pass(sc_pass),
    .new_val(new_val), .we(mem_we), .ok(op_ok)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int a = 0; a < DEPTH; a++) mem_q[a] <= '0;
    end else if (fire && mem_we) begin
      mem_q[sel_addr] <= new_val;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_id    <= '0;
      rsp_rdata <= '0;
      rsp_ok    <= 1'b0;
    end else if (fire) begin
      rsp_valid <= 1'b1;
      rsp_id    <= gnt_id;
      rsp_rdata <= old_val;
      rsp_ok    <= op_ok;
    end else if (rsp_ready) begin
      rsp_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/amo_unit_chk.sv
module amo_unit_chk
  import amo_pkg::*;
#(
  parameter int NREQ = 3,
  parameter int DW   = 16,
  parameter int IDW  = 2
) (
  input logic            clk,
  input logic            rst_n,
  input logic [NREQ-1:0] req_valid,
  input logic [NREQ-1:0] req_ready,
  input logic            rsp_valid,
  input logic            rsp_ready,
  input logic [IDW-1:0]  rsp_id,
  input logic [DW-1:0]   rsp_rdata,
  input logic            rsp_ok,
  input logic [NREQ-1:0] ctx_switch,
  input logic [NREQ-1:0] res_flag,
  input logic            fire,
  input logic [2:0]      sel_op,
  input logic            sc_pass,
  input logic            mem_we
);
  AST_ONE_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(req_valid & req_ready)); // R10

  AST_RSP_AFTER_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
    (|(req_valid & req_ready)) |=> rsp_valid); // R10

  AST_RSP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_id) && $stable(rsp_rdata) && $stable(rsp_ok))); // R11

  AST_NO_GRANT_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |-> (req_ready == '0)); // R11

  AST_CTX_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (ctx_switch != '0) |=> ((res_flag & $past(ctx_switch)) == '0)); // R9

  AST_SC_FAIL_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && sel_op == AMO_SC && !sc_pass) |-> !mem_we); // R7
endmodule

bind amo_unit amo_unit_chk #(.NREQ(NREQ), .DW(DW), .IDW(IDW)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_id(rsp_id),
  .rsp_rdata(rsp_rdata), .rsp_ok(rsp_ok), .ctx_switch(ctx_switch),
  .res_flag(res_flag), .fire(fire), .sel_op(sel_op), .sc_pass(sc_pass),
  .mem_we(mem_we)
);

// File: tb/amo_unit_tb.sv
module amo_unit_tb;
  localparam int NREQ = 3;
  localparam int AW   = 4;
  localparam int DW   = 16;
  localparam int IDW  = 2;
  localparam int NV   = 30;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic [NREQ-1:0]   req_valid = '0;
  logic [NREQ-1:0]   req_ready;
  logic [3*NREQ-1:0] req_op = '0;
  logic [AW*NREQ-1:0] req_addr = '0;
  logic [DW*NREQ-1:0] req_wdata = '0;
  logic [NREQ-1:0]   ctx_switch = '0;
  logic              rsp_valid;
  logic              rsp_ready = 1'b1;
  logic [IDW-1:0]    rsp_id;
  logic [DW-1:0]     rsp_rdata;
  logic              rsp_ok;

  int n_chk = 0;
  int n_fail = 0;

  always #10 clk = ~clk;

  amo_unit #(.NREQ(NREQ), .AW(AW), .DW(DW)) u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_op(req_op), .req_addr(req_addr), .req_wdata(req_wdata),
    .ctx_switch(ctx_switch), .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
    .rsp_id(rsp_id), .rsp_rdata(rsp_rdata), .rsp_ok(rsp_ok)
  );

  // fields: req tag(4) id(2) op(3) addr(4) wdata(16) exp_rdata(16) exp_ok(1)
  localparam logic [45:0] VEC [NV] = '{
    {4'd2,  2'd0, 3'd0, 4'd3,  16'h0000, 16'h0000, 1'b1}, // R2 load
    {4'd2,  2'd0, 3'd1, 4'd3,  16'h1234, 16'h0000, 1'b1}, // R2 store
    {4'd2,  2'd1, 3'd0, 4'd3,  16'h0000, 16'h1234, 1'b1}, // R2 readback
    {4'd3,  2'd0, 3'd2, 4'd5,  16'h0000, 16'h0000, 1'b1}, // R3 tas free
    {4'd3,  2'd1, 3'd2, 4'd5,  16'h0000, 16'h0001, 1'b1}, // R3 tas held
    {4'd4,  2'd0, 3'd3, 4'd3,  16'h0010, 16'h1234, 1'b1}, // R4 add
    {4'd4,  2'd2, 3'd3, 4'd3,  16'hFFFF, 16'h1244, 1'b1}, // R4 wrap
    {4'd5,  2'd1, 3'd4, 4'd3,  16'hBEEF, 16'h1243, 1'b1}, // R5 swap
    {4'd5,  2'd2, 3'd0, 4'd3,  16'h0000, 16'hBEEF, 1'b1}, // R5 readback
    {4'd6,  2'd0, 3'd5, 4'd7,  16'h0000, 16'h0000, 1'b1}, // R6 ll
    {4'd6,  2'd0, 3'd6, 4'd7,  16'h0055, 16'h0000, 1'b1}, // R6 sc ok
    {4'd6,  2'd0, 3'd6, 4'd7,  16'h0066, 16'h0055, 1'b0}, // R6 reservation consumed
    {4'd7,  2'd1, 3'd0, 4'd7,  16'h0000, 16'h0055, 1'b1}, // R7 no write
    {4'd8,  2'd1, 3'd5, 4'd7,  16'h0000, 16'h0055, 1'b1}, // R8 ll
    {4'd8,  2'd2, 3'd1, 4'd7,  16'h0077, 16'h0055, 1'b1}, // R8 foreign store
    {4'd8,  2'd1, 3'd6, 4'd7,  16'h0088, 16'h0077, 1'b0}, // R8 sc fails
    {4'd7,  2'd1, 3'd0, 4'd7,  16'h0000, 16'h0077, 1'b1}, // R7 no write
    {4'd8,  2'd2, 3'd5, 4'd8,  16'h0000, 16'h0000, 1'b1}, // R8 ll
    {4'd8,  2'd2, 3'd1, 4'd8,  16'h0011, 16'h0000, 1'b1}, // R8 own store
    {4'd8,  2'd2, 3'd6, 4'd8,  16'h0022, 16'h0011, 1'b1}, // R8 sc ok
    {4'd6,  2'd0, 3'd0, 4'd8,  16'h0000, 16'h0022, 1'b1}, // R6 readback
    {4'd8,  2'd0, 3'd5, 4'd9,  16'h0000, 16'h0000, 1'b1}, // R8 ll
    {4'd8,  2'd1, 3'd2, 4'd9,  16'h0000, 16'h0000, 1'b1}, // R8 foreign tas
    {4'd8,  2'd0, 3'd6, 4'd9,  16'h0005, 16'h0001, 1'b0}, // R8 sc fails
    {4'd8,  2'd0, 3'd5, 4'd10, 16'h0000, 16'h0000, 1'b1}, // R8 ll
    {4'd8,  2'd1, 3'd1, 4'd11, 16'h0003, 16'h0000, 1'b1}, // R8 other addr
    {4'd8,  2'd0, 3'd6, 4'd10, 16'h0009, 16'h0000, 1'b1}, // R8 sc ok
    {4'd6,  2'd1, 3'd0, 4'd10, 16'h0000, 16'h0009, 1'b1}, // R6 readback
    {4'd2,  2'd0, 3'd7, 4'd3,  16'h0001, 16'hBEEF, 1'b1}, // R2 op 7
    {4'd2,  2'd0, 3'd0, 4'd3,  16'h0000, 16'hBEEF, 1'b1}  // R2 op 7 no write
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic issue(input int id, input logic [2:0] op, input logic [AW-1:0] addr,
                       input logic [DW-1:0] wd, output logic [DW+IDW+1:0] got);
    @(negedge clk);
    req_op[id*3 +: 3]     = op;
    req_addr[id*AW +: AW] = addr;
    req_wdata[id*DW +: DW] = wd;
    req_valid[id]         = 1'b1;
    @(negedge clk);
    req_valid[id] = 1'b0;
    got = {rsp_valid, rsp_id, rsp_rdata, rsp_ok};
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_fail++;
    n_chk++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    logic [DW+IDW+1:0] got;
    repeat (3) @(negedge clk);
    chk("R1 rsp_valid after reset", 32'(rsp_valid), 32'd0);
    rst_n = 1'b1;

    issue(0, 3'd0, 4'd15, '0, got);
    chk("R1 memory zero", 32'(got), 32'({1'b1, 2'd0, 16'h0, 1'b1}));

    for (int v = 0; v < NV; v++) begin
      logic [45:0] e;
      e = VEC[v];
      issue(int'(e[41:40]), e[39:37], e[36:33], e[32:17], got);
      chk($sformatf("R%0d vector %0d", e[45:42], v), 32'(got),
          32'({1'b1, e[41:40], e[16:1], e[0]}));
    end

    // R9: context switch clears own reservation
    issue(1, 3'd5, 4'd12, '0, got);
    @(negedge clk); ctx_switch[1] = 1'b1;
    @(negedge clk); ctx_switch[1] = 1'b0;
    issue(1, 3'd6, 4'd12, 16'h0004, got);
    chk("R9 sc after own ctx switch", 32'(got), 32'({1'b1, 2'd1, 16'h0, 1'b0}));
    issue(0, 3'd0, 4'd12, '0, got);
    chk("R9 no write after ctx switch", 32'(got[DW:1]), 32'h0);
    // R9: foreign context switch leaves reservation
    issue(1, 3'd5, 4'd12, '0, got);
    @(negedge clk); ctx_switch[0] = 1'b1;
    @(negedge clk); ctx_switch[0] = 1'b0;
    issue(1, 3'd6, 4'd12, 16'h0004, got);
    chk("R9 foreign ctx switch kept", 32'(got), 32'({1'b1, 2'd1, 16'h0, 1'b1}));

    // R10: three concurrent test-and-set on one word
    begin
      int zeros;
      logic [NREQ-1:0] seen;
      zeros = 0;
      seen  = '0;
      @(negedge clk);
      for (int i = 0; i < NREQ; i++) begin
        req_op[i*3 +: 3]     = 3'd2;
        req_addr[i*AW +: AW] = 4'd13;
      end
      req_valid = '1;
      for (int c = 0; c < NREQ; c++) begin
        @(negedge clk);
        chk("R10 response each cycle", 32'(rsp_valid), 32'd1);
        seen[rsp_id]      = 1'b1;
        req_valid[rsp_id] = 1'b0;
        if (rsp_rdata == '0) zeros++;
      end
      chk("R10 every port served once", 32'(seen), 32'b111);
      chk("R10 one winner of tas", 32'(zeros), 32'd1);
    end

    // R11: back-pressure
    @(negedge clk);
    rsp_ready = 1'b0;
    req_op[2:0] = 3'd0; req_addr[AW-1:0] = 4'd3; req_valid[0] = 1'b1;
    @(negedge clk);
    req_valid[0] = 1'b0;
    req_op[5:3] = 3'd0; req_addr[2*AW-1:AW] = 4'd8; req_valid[1] = 1'b1;
    #1;
    chk("R11 no ready while stalled", 32'(req_ready), 32'd0);
    @(negedge clk);
    chk("R11 response held", 32'({rsp_valid, rsp_id, rsp_rdata}), 32'({1'b1, 2'd0, 16'hBEEF}));
    rsp_ready = 1'b1;
    @(negedge clk);
    req_valid[1] = 1'b0;
    chk("R11 next after release", 32'({rsp_valid, rsp_id, rsp_rdata}), 32'({1'b1, 2'd1, 16'h0022}));

    // R1: reset in mid-run
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk);
    chk("R1 rsp_valid in reset", 32'(rsp_valid), 32'd0);
    rst_n = 1'b1;
    issue(2, 3'd0, 4'd3, '0, got);
    chk("R1 memory cleared", 32'(got), 32'({1'b1, 2'd2, 16'h0, 1'b1}));

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule